// File: doc/BRIEF.md
# Randomized Iterative Crossbar Matcher

This block pairs the N ingress ports of an input-queued crossbar with its N egress ports. Each ingress port keeps one queue per egress port. A start strobe captures an N×N request matrix, and the block then runs a sequence of matching rounds, one per clock cycle. In each round, every egress port that is still free offers itself to one of its requesting free ingress ports, picked at random. Each free ingress port that receives one or more offers takes one of them at random. The rounds end when a round adds no new pair, or when a configurable round budget is used up.

The random picks come from a private linear feedback shift register for every egress port and every ingress port, each with its own reset seed. A pick takes the register value modulo N as a start position and searches upward, with wrap-around, for the first candidate. The result is a match matrix with at most one bit in any row or column, plus a per-ingress egress index with a valid bit. The result is held until the next start. A one-cycle done pulse marks the end of the slot.

Top module: `rand_xbar_matcher`

## Requirements
- R1: On start_i high at a rising edge, the request matrix is captured and the match matrix is cleared. Changes on req_i during the slot have no effect on the result.
- R2: Bit i*N+j of req_i and match_o means ingress i / egress j. A pair is only ever matched if its captured request bit is set.
- R3: match_o has at most one bit set in every row (ingress) and every column (egress).
- R4: Pairs formed in earlier rounds stay matched and only grow during a slot. A request pattern in which every ingress and every egress appears at most once is fully matched in the first round.
- R5: One round per cycle. done_o is high in the cycle after edge k+L, where k is the start edge and L counts every round run, including the final round that adds no pair. An empty request gives L=1.
- R6: No slot runs more than ITER_MAX rounds (default log2(N)+1).
- R7: done_o is a one-cycle pulse. After it, match_o holds until the next start.
- R8: When a slot ends before the round budget, the match is maximal: no captured request has both its ingress and its egress unmatched.
- R9: gnt_vld_o[i] is set exactly when row i of match_o is non-empty. gnt_idx_o field i (IDXW bits at i*IDXW) then holds the matched egress index.
- R10: While rst_n is low, match_o, gnt_vld_o and done_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a slot and capture req_i |
| req_i | input | N*N | Request matrix, bit i*N+j = ingress i has a cell for egress j |
| match_o | output | N*N | Match matrix, same bit layout |
| gnt_idx_o | output | N*IDXW | Matched egress index per ingress |
| gnt_vld_o | output | N | Ingress has a match |
| done_o | output | 1 | One-cycle pulse: slot finished |

## Verification
The done pulse is due L edges after the start edge, where L is the round count. For deterministic patterns, L is known exactly from R5: permutations and single pairs need two rounds, and an empty request needs one. The bench samples on falling edges and counts the edges from the start edge to the first done. It compares that count with the expected L, or checks it against the budget when the picks are random. The match and index outputs are checked in the done cycle and again one cycle later, to confirm they hold. Randomly resolved patterns are judged by rules that hold for every outcome: subset of the request, one bit per row and column, and maximality when the slot ended early.

// File: rtl/rx_match_pkg.sv
package rx_match_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  // Distinct non-zero seed per generator: high byte is k+1.
  function automatic logic [LFSR_W-1:0] seed_of(input int k);
    logic [7:0] hi;
    logic [7:0] lo;
    hi = 8'(k + 1);
    lo = 8'hA5 ^ 8'(k * 37);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/rx_lfsr.sv
module rx_lfsr
  import rx_match_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] state_q, state_n;

  always_comb begin
    state_n = state_q;
    if (en) begin
      if (state_q[0]) state_n = (state_q >> 1) ^ LFSR_TAPS;
      else            state_n = state_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_n;
  end

  assign state_o = state_q;
endmodule

// File: rtl/rx_rot_pick.sv
module rx_rot_pick #(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic [W-1:0]  cand,
  input  logic [IW-1:0] start,
  output logic [W-1:0]  pick
);
  always_comb begin
    logic hit;
    int   p;
    pick = '0;
    hit  = 1'b0;
    for (int k = 0; k < W; k++) begin
      p = (int'(start) + k) % W;
      if (!hit && cand[p]) begin
        pick[p] = 1'b1;
        hit     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rand_xbar_matcher.sv
module rand_xbar_matcher
  import rx_match_pkg::*;
#(
  parameter int N        = 4,
  parameter int ITER_MAX = $clog2(N) + 1,
  parameter int IDXW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [N*N-1:0]    req_i,
  output logic [N*N-1:0]    match_o,
  output logic [N*IDXW-1:0] gnt_idx_o,
  output logic [N-1:0]      gnt_vld_o,
  output logic              done_o
);
  localparam int CNTW = $clog2(ITER_MAX + 1);

  logic [N*N-1:0]  req_q, match_q, match_n, req_n, acc_flat;
  logic            busy_q, busy_n, done_q, done_n;
  logic [CNTW-1:0] iter_q, iter_n;
  logic            lfsr_en;

  logic [N-1:0] in_free, out_free;
  logic [N-1:0] col_req [N];   // col_req[j][i]: ingress i requests egress j
  logic [N-1:0] gnt_col [N];   // gnt_col[j][i]: egress j offers to ingress i
  logic [N-1:0] row_gnt [N];   // row_gnt[i][j]
  logic [N-1:0] acc_row [N];   // acc_row[i][j]
  logic [IDXW-1:0] out_rnd [N];
  logic [IDXW-1:0] in_rnd  [N];

  assign lfsr_en = busy_q | start_i;

  // Random start positions, one generator per egress and per ingress
  for (genvar g = 0; g < 2 * N; g++) begin : g_rng
    logic [LFSR_W-1:0] st;
    rx_lfsr #(.SEED(seed_of(g))) u_lfsr (
      .clk(clk), .rst_n(rst_n), .en(lfsr_en), .state_o(st)
    );
    if (g < N) begin : g_out
      assign out_rnd[g] = IDXW'(st % LFSR_W'(N));
    end else begin : g_in
      assign in_rnd[g-N] = IDXW'(st % LFSR_W'(N));
    end
  end

  // Free ports and eligible requests
  always_comb begin
    for (int i = 0; i < N; i++) begin
      in_free[i]  = 1'b1;
      out_free[i] = 1'b1;
    end
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (match_q[i*N+j]) begin
          in_free[i]  = 1'b0;
          out_free[j] = 1'b0;
        end
      end
    end
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        col_req[j][i] = req_q[i*N+j] & in_free[i] & out_free[j];
      end
    end
  end

  // Grant stage: one pick per egress
  for (genvar j = 0; j < N; j++) begin : g_gnt
    rx_rot_pick #(.W(N), .IW(IDXW)) u_pick (
      .cand(col_req[j]), .start(out_rnd[j]), .pick(gnt_col[j])
    );
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        row_gnt[i][j] = gnt_col[j][i];
      end
    end
  end

  // Accept stage: one pick per ingress
  for (genvar i = 0; i < N; i++) begin : g_acc
    rx_rot_pick #(.W(N), .IW(IDXW)) u_pick (
      .cand(row_gnt[i]), .start(in_rnd[i]), .pick(acc_row[i])
    );
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        acc_flat[i*N+j] = acc_row[i][j];
      end
    end
  end

  // Slot control, next state
  always_comb begin
    logic last;
    req_n   = req_q;
    match_n = match_q;
    busy_n  = busy_q;
    iter_n  = iter_q;
    done_n  = 1'b0;
    last    = (acc_flat == '0) || (iter_q == CNTW'(ITER_MAX - 1));
    if (start_i) begin
      req_n   = req_i;
      match_n = '0;
      busy_n  = 1'b1;
      iter_n  = '0;
    end else if (busy_q) begin
      match_n = match_q | acc_flat;
      iter_n  = iter_q + 1'b1;
      if (last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      match_q <= '0;
      busy_q  <= 1'b0;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      req_q   <= req_n;
      match_q <= match_n;
      busy_q  <= busy_n;
      iter_q  <= iter_n;
      done_q  <= done_n;
    end
  end

  // Per-ingress index encoding
  always_comb begin
    gnt_idx_o = '0;
    gnt_vld_o = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (match_q[i*N+j]) begin
          gnt_idx_o[i*IDXW +: IDXW] = IDXW'(j);
          gnt_vld_o[i]              = 1'b1;
        end
      end
    end
  end

  assign match_o = match_q;
  assign done_o  = done_q;
endmodule

// File: rtl/rx_match_chk.sv
module rx_match_chk #(
  parameter int N        = 4,
  parameter int ITER_MAX = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           done_o,
  input logic           busy_q,
  input logic [N*N-1:0] match_o
);
  logic [N-1:0] col_v [N];
  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        col_v[j][i] = match_o[i*N+j];
  end

  for (genvar r = 0; r < N; r++) begin : g_rc
    // R3
    row_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_o[r*N +: N]));
    // R3
    col_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_v[r]));
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> $stable(match_o));

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (match_o == '0));

  // R4
  grow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start_i) |=> (($past(match_o) & ~match_o) == '0));

  // R6: round counter kept here instead of a long $past window
  int rounds;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rounds <= 0;
    else if (start_i) rounds <= 0;
    else if (busy_q)  rounds <= rounds + 1;
  end
  // R6
  round_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rounds <= ITER_MAX);
endmodule

bind rand_xbar_matcher rx_match_chk #(.N(N), .ITER_MAX(ITER_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .busy_q(busy_q), .match_o(match_o)
);

// File: tb/rand_xbar_matcher_bench.sv
module rand_xbar_matcher_bench;
  localparam int N    = 4;
  localparam int IDXW = 2;
  localparam int CAP  = 3;
  localparam int NV   = 10;

  // Vector table: request, expected match, expected rounds (0 = random outcome)
  localparam logic [15:0] V_REQ [NV] = '{16'h8421, 16'h1248, 16'h0200, 16'h0000, 16'h2004,
                                         16'hFFFF, 16'h0011, 16'h00F0, 16'h0F0F, 16'h137F};
  localparam logic [15:0] V_EXP [NV] = '{16'h8421, 16'h1248, 16'h0200, 16'h0000, 16'h2004,
                                         16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam int          V_IT  [NV] = '{2, 2, 2, 1, 2, 0, 0, 0, 0, 0};

  logic clk, rst_n, start_i, done_o;
  logic [N*N-1:0]    req_i, match_o;
  logic [N*IDXW-1:0] gnt_idx_o;
  logic [N-1:0]      gnt_vld_o;

  int n_run, n_fail;
  bit finished;

  rand_xbar_matcher #(.N(N)) u_rand_xbar_matcher (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
    .match_o(match_o), .gnt_idx_o(gnt_idx_o), .gnt_vld_o(gnt_vld_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Generic rules valid for any random outcome
  task automatic check_legal(input logic [15:0] req, input int lat);
    logic [N-1:0] ri, co;
    bit one_ok, max_ok, idx_ok;
    ri = '0; co = '0; one_ok = 1; max_ok = 1; idx_ok = 1;
    for (int i = 0; i < N; i++) begin
      int cnt_r, cnt_c;
      cnt_r = 0; cnt_c = 0;
      for (int j = 0; j < N; j++) begin
        cnt_r += match_o[i*N+j];
        cnt_c += match_o[j*N+i];
        if (match_o[i*N+j]) begin
          ri[i] = 1; co[j] = 1;
          if (gnt_idx_o[i*IDXW +: IDXW] != IDXW'(j)) idx_ok = 0;
        end
      end
      if (cnt_r > 1 || cnt_c > 1) one_ok = 0;
    end
    // R2
    check((match_o & ~req) == 0, "R2 subset", match_o, req);
    // R3
    check(one_ok, "R3 one per row/col", match_o, 0);
    // R9
    check(idx_ok && (gnt_vld_o == ri), "R9 index/valid", {gnt_idx_o, gnt_vld_o}, ri);
    // R6
    check(lat <= CAP, "R6 round budget", lat, CAP);
    if (lat < CAP) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (req[i*N+j] && !ri[i] && !co[j]) max_ok = 0;
      // R8
      check(max_ok, "R8 maximal", match_o, req);
    end
  endtask

  task automatic run_slot(input logic [15:0] req, input logic [15:0] exp, input int it);
    int lat;
    logic [15:0] held;
    @(negedge clk);
    req_i = req; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    req_i = ~req;            // R1: later changes must be ignored
    lat = 0;
    do begin
      if (lat > 0 || 1) begin end
      lat++;
      if (!done_o) @(negedge clk);
    end while (!done_o && lat < 20);
    // lat counts edges after start edge; first iteration of loop is at k+... adjust
    check(done_o == 1'b1, "R5 done seen", done_o, 1);
    if (it != 0) begin
      // R5
      check(lat == it, "R5 latency", lat, it);
      // R1 R4
      check(match_o == exp, "R4 deterministic match", match_o, exp);
    end
    check_legal(req, lat);
    held = match_o;
    @(negedge clk);
    // R7
    check(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    check(match_o == held, "R7 match held", match_o, held);
  endtask

  initial begin
    n_run = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; start_i = 1'b0; req_i = '0;
    repeat (3) @(negedge clk);
    // R10
    check(match_o == 0 && gnt_vld_o == 0 && done_o == 0, "R10 reset state",
          {match_o, gnt_vld_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) run_slot(V_REQ[v], V_EXP[v], V_IT[v]);

    // Repeated full load exercises different random picks and the budget
    for (int r = 0; r < 12; r++) run_slot(16'hFFFF, 16'h0, 0);

    // Idle gap: match stays after several cycles without start (R7)
    begin
      logic [15:0] h;
      h = match_o;
      req_i = 16'h0000;
      repeat (5) @(negedge clk);
      check(match_o == h, "R7 idle hold", match_o, h);
    end

    // Start clears previous result (R1)
    @(negedge clk);
    req_i = 16'h0000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(match_o == 0, "R1 start clears", match_o, 0);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule